// File: doc/BRIEF.md
# Mirrored Sound-Register Capture Unit

This unit watches processor accesses to a 1 KB I/O window. Inside that window a 32-byte sound register file repeats every 32 bytes. The unit folds each mirrored address back onto the base register index. It holds one byte: the last value written anywhere in the window. For every write to a folded register, it also records two sticky flags for that register, based on bit 0 of the data: a key-on flag and a key-off flag. The three highest offsets of each 32-byte slot are not folded. A write there lands in a small store addressed by the actual address, and a read there returns that stored byte. Folded reads return the last written byte. The two exceptions are the oscillator-3 and envelope-3 offsets, which return two live external inputs.

Accesses arrive on a valid/ready request channel. Read data leaves on a valid/ready response channel. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` drops only while a response is waiting and `rsp_ready` is low. This is the one form of back-pressure: a stalled consumer of read data holds off new requests. A response is issued only for an accepted read that hits the window while `io_en` is high. Other accepted requests complete silently. A one-cycle `sess_clr` pulse starts a new session by clearing the flags of the three voice control registers.

Top module: `snd_mirror_cap`

## Requirements
- R1: A request is handled only when `req_addr[15:10]` equals 6'b110101, which is the same as `(addr & 16'hFC1F)` having upper byte 8'hD4. Any other accepted request gives no response and changes no flag, stored byte or last value.
- R2: A write whose low five address bits `addr[4:0]` are below 5'h1D is a folded write to register index `addr[4:0]`. In the cycle after acceptance, it sets `key_on[index]` if `wdata[0]` is 1, or `key_off[index]` if `wdata[0]` is 0.
- R3: Flags are sticky. No write ever clears a set bit of `key_on` or `key_off`.
- R4: Every handled write, folded or not, replaces the last value. A folded read of any index other than 5'h1B and 5'h1C returns the last value as it stood when the read was accepted.
- R5: A folded read of index 5'h1B returns `osc3_in`, and one of index 5'h1C returns `env3_in`, each sampled on the edge that accepts the read.
- R6: A handled write with `addr[4:0]` at 5'h1D or above is stored at its actual address, indexed by `{addr[9:5], addr[1:0]}`, so all 32 mirrors are distinct. A read at such an address returns that byte. Such a write leaves both flag vectors unchanged.
- R7: A cycle with `sess_clr` high clears bits 4, 11 and 18 of both `key_on` and `key_off` on the next edge and leaves every other bit alone. If a write sets one of those bits in the same cycle, the clear wins.
- R8: While `io_en` is low, accepted requests give no response and change no flag, stored byte or last value.
- R9: `rsp_valid` rises on the edge after a handled read is accepted. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold steady and `req_ready` is low.
- R10: After reset, `key_on` and `key_off` are all zero, `rsp_valid` is low, `req_ready` is high, and the last value and all stored bytes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| io_en | input | 1 | I/O region active; when low, all accesses are ignored |
| sess_clr | input | 1 | Session-start pulse that clears the voice control flags |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 8 | Read data |
| osc3_in | input | 8 | Live oscillator-3 value |
| env3_in | input | 8 | Live envelope-3 value |
| key_on | output | 32 | Sticky key-on flag per register index |
| key_off | output | 32 | Sticky key-off flag per register index |

## Verification
The random stream mixes addresses from across the whole window with addresses outside it. Within the window, low offsets are biased toward the three unfolded ones and the two live-input indices. This tells a correct 6-bit window match apart from a narrower or wider mask, and folded handling apart from unfolded handling. Write data with bit 0 at both values, together with occasional low `io_en` and `sess_clr`, separates the two flag vectors, stickiness and the selective clear. Directed cases cover:
- a write to a mirror that must fold onto the base index;
- two mirrors of offset 5'h1D that must hold different bytes;
- addresses one step outside each end of the window;
- a session clear in the same cycle as a write to index 4;
- a response held back by `rsp_ready`.

// File: rtl/snd_cap_pkg.sv
package snd_cap_pkg;
  parameter int ADDR_W = 16;
  parameter int DATA_W = 8;
  parameter int IDX_W  = 5;
  parameter int MIR_W  = 5;
  parameter int LOW_W  = 2;
  localparam int NUM_REGS = 1 << IDX_W;
  localparam int TAG_W    = ADDR_W - MIR_W - IDX_W;
  localparam int HI_AW    = MIR_W + LOW_W;
  localparam int HI_DEPTH = 1 << HI_AW;

  localparam logic [TAG_W-1:0]    WIN_TAG   = 6'b110101;
  localparam logic [IDX_W-1:0]    HI_FIRST  = 5'h1D;
  localparam logic [IDX_W-1:0]    OSC_IDX   = 5'h1B;
  localparam logic [IDX_W-1:0]    ENV_IDX   = 5'h1C;
  localparam logic [NUM_REGS-1:0] CLR_MASK  = 32'h0004_0810;

  typedef struct packed {
    logic             hit;
    logic             folded;
    logic [IDX_W-1:0] reg_idx;
    logic [HI_AW-1:0] hi_idx;
  } win_dec_t;
endpackage

// File: rtl/snd_win_decode.sv
module snd_win_decode
  import snd_cap_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output win_dec_t          dec
);
  logic [TAG_W-1:0] tag;
  logic [MIR_W-1:0] mirror;
  logic [IDX_W-1:0] low;

  always_comb begin
    tag    = addr[ADDR_W-1 -: TAG_W];
    mirror = addr[IDX_W +: MIR_W];
    low    = addr[IDX_W-1:0];
    dec.hit     = (tag == WIN_TAG);
    dec.folded  = (low < HI_FIRST);
    dec.reg_idx = low;
    dec.hi_idx  = {mirror, low[LOW_W-1:0]};
  end
endmodule

// File: rtl/snd_key_flags.sv
module snd_key_flags
  import snd_cap_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic                wr_bit,
  input  logic                clr_pulse,
  output logic [NUM_REGS-1:0] key_on,
  output logic [NUM_REGS-1:0] key_off
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flag
    logic sel;
    logic clr;
    assign sel = wr_en && (wr_idx == IDX_W'(g));
    assign clr = clr_pulse && CLR_MASK[g];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        key_on[g]  <= 1'b0;
        key_off[g] <= 1'b0;
      end else if (clr) begin
        key_on[g]  <= 1'b0;
        key_off[g] <= 1'b0;
      end else if (sel) begin
        if (wr_bit) key_on[g]  <= 1'b1;
        else        key_off[g] <= 1'b1;
      end
    end
  end

  // R3
  sticky_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_pulse |=> ((key_on & $past(key_on)) == $past(key_on)));
  // R3
  sticky_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_pulse |=> ((key_off & $past(key_off)) == $past(key_off)));
  // R7
  sess_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> (((key_on | key_off) & CLR_MASK) == '0));
  // R2
  key_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr_pulse) |=> (wr_bit ? key_on[$past(wr_idx)] : key_off[$past(wr_idx)]));
endmodule

// File: rtl/snd_hi_store.sv
module snd_hi_store
  import snd_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [HI_AW-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [HI_AW-1:0]  rd_idx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [HI_DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < HI_DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wdata;
    end
  end

  assign rdata = mem[rd_idx];
endmodule

// File: rtl/snd_mirror_cap.sv
module snd_mirror_cap
  import snd_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_en,
  input  logic              sess_clr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [15:0]       req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_data,
  input  logic [7:0]        osc3_in,
  input  logic [7:0]        env3_in,
  output logic [31:0]       key_on,
  output logic [31:0]       key_off
);
  win_dec_t          dec;
  logic              accept;
  logic              handled;
  logic              wr_evt;
  logic              rd_evt;
  logic [DATA_W-1:0] last_val;
  logic [DATA_W-1:0] hi_rdata;
  logic [DATA_W-1:0] rd_sel;

  snd_win_decode u_dec (
    .addr (req_addr),
    .dec  (dec)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign handled   = accept && io_en && dec.hit;
  assign wr_evt    = handled && req_write;
  assign rd_evt    = handled && !req_write;

  snd_key_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_evt && dec.folded),
    .wr_idx    (dec.reg_idx),
    .wr_bit    (req_wdata[0]),
    .clr_pulse (sess_clr),
    .key_on    (key_on),
    .key_off   (key_off)
  );

  snd_hi_store u_hi (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_evt && !dec.folded),
    .wr_idx (dec.hi_idx),
    .wdata  (req_wdata),
    .rd_idx (dec.hi_idx),
    .rdata  (hi_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      last_val <= '0;
    else if (wr_evt) last_val <= req_wdata;
  end

  always_comb begin
    if (!dec.folded)                 rd_sel = hi_rdata;
    else if (dec.reg_idx == OSC_IDX) rd_sel = osc3_in;
    else if (dec.reg_idx == ENV_IDX) rd_sel = env3_in;
    else                             rd_sel = last_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_evt) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_sel;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  // R9
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
  // R8
  io_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_en && !sess_clr) |=> ($stable(key_on) && $stable(key_off) && $stable(last_val)));
  // R1
  outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !dec.hit && !sess_clr && !(rsp_valid && !rsp_ready))
      |=> ($stable(key_on) && $stable(key_off) && !$rose(rsp_valid)));
endmodule

// File: tb/snd_mirror_cap_tb_top.sv
module snd_mirror_cap_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_en = 1'b1;
  logic        sess_clr = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [7:0]  rsp_data;
  logic [7:0]  osc3_in = '0;
  logic [7:0]  env3_in = '0;
  logic [31:0] key_on;
  logic [31:0] key_off;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0]  m_last;
  logic [7:0]  m_hi [128];
  logic [31:0] m_on;
  logic [31:0] m_off;
  localparam logic [31:0] CLR_BITS = 32'h0004_0810;

  snd_mirror_cap dut_i (.*);

  always #5 clk = ~clk;

  function automatic bit f_hit(logic [15:0] a);
    return a[15:10] == 6'b110101;
  endfunction

  function automatic logic [7:0] f_read(logic [15:0] a);
    if (a[4:0] >= 5'h1D) return m_hi[{a[9:5], a[1:0]}];
    if (a[4:0] == 5'h1B) return osc3_in;
    if (a[4:0] == 5'h1C) return env3_in;
    return m_last;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(bit wr, logic [15:0] a, logic [7:0] d, bit sc, string req);
    logic [7:0] exp_rd;
    bit exp_rsp;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; sess_clr = sc;
    exp_rsp = !wr && io_en && f_hit(a);
    exp_rd  = f_read(a);
    if (wr && io_en && f_hit(a)) begin
      m_last = d;
      if (a[4:0] >= 5'h1D) m_hi[{a[9:5], a[1:0]}] = d;
      else if (d[0]) m_on[a[4:0]] = 1'b1;
      else m_off[a[4:0]] = 1'b1;
    end
    if (sc) begin
      m_on  = m_on & ~CLR_BITS;
      m_off = m_off & ~CLR_BITS;
    end
    @(negedge clk);
    req_valid = 1'b0; sess_clr = 1'b0;
    chk(rsp_valid == exp_rsp, {req, " rsp_valid"}, 32'(rsp_valid), 32'(exp_rsp));
    if (exp_rsp) chk(rsp_data == exp_rd, {req, " rsp_data"}, 32'(rsp_data), 32'(exp_rd));
    chk(key_on == m_on, {req, " key_on"}, key_on, m_on);
    chk(key_off == m_off, {req, " key_off"}, key_off, m_off);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_last = '0; m_on = '0; m_off = '0;
    for (int i = 0; i < 128; i++) m_hi[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(key_on == 0 && key_off == 0, "R10 flags", key_on | key_off, 0);
    chk(rsp_valid == 0 && req_ready == 1, "R10 handshake", {rsp_valid, req_ready}, 32'b01);
    op(0, 16'hD400, 0, 0, "R10 last value zero");
    op(0, 16'hD7FF, 0, 0, "R10 store zero");

    // R2 folded write via a mirror lands on index 4
    op(1, 16'hD4E4, 8'h41, 0, "R2 mirror fold");
    op(1, 16'hD5A4, 8'h40, 0, "R2 key off");
    // R3 another set does not clear
    op(1, 16'hD404, 8'h01, 0, "R3 sticky");
    // R4 last value readback
    op(0, 16'hD610, 0, 0, "R4 last value");
    // R5 live inputs
    osc3_in = 8'h5A; env3_in = 8'hC3;
    op(0, 16'hD43B, 0, 0, "R5 osc3");
    op(0, 16'hD7FC, 0, 0, "R5 env3");
    // R6 two mirrors of 0x1D are distinct and flags untouched
    op(1, 16'hD41D, 8'h11, 0, "R6 write a");
    op(1, 16'hD43D, 8'h22, 0, "R6 write b");
    op(0, 16'hD41D, 0, 0, "R6 read a");
    op(0, 16'hD43D, 0, 0, "R6 read b");
    op(0, 16'hD400, 0, 0, "R4 last after unfolded");
    // R1 just outside both ends
    op(1, 16'hD3FF, 8'h99, 0, "R1 below");
    op(1, 16'hD800, 8'h98, 0, "R1 above");
    op(0, 16'hD800, 0, 0, "R1 read outside");
    op(0, 16'hD401, 0, 0, "R1 last unchanged");
    // R8 io disabled
    io_en = 1'b0;
    op(1, 16'hD407, 8'h77, 0, "R8 write ignored");
    op(0, 16'hD407, 0, 0, "R8 read ignored");
    io_en = 1'b1;
    op(0, 16'hD407, 0, 0, "R8 last unchanged");
    // R7 clear wins over same-cycle write to index 4
    op(1, 16'hD40B, 8'h01, 0, "R7 prep");
    op(1, 16'hD404, 8'h01, 1, "R7 clear wins");
    chk(key_on[4] == 0 && key_on[11] == 0, "R7 bits cleared", key_on, m_on);
    // R9 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'hD41D;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(rsp_valid && !req_ready && rsp_data == 8'h11, "R9 hold",
          {rsp_valid, req_ready, rsp_data}, {1'b1, 1'b0, 8'h11});
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 0, "R9 release", 32'(rsp_valid), 0);

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [15:0] a;
      logic [4:0]  lo;
      int r = $urandom_range(0, 9);
      lo = (r < 3) ? 5'(5'h1B + $urandom_range(0, 4)) : 5'($urandom_range(0, 31));
      a = ($urandom_range(0, 9) < 8) ? {6'b110101, 5'($urandom_range(0, 31)), lo}
                                     : 16'($urandom_range(0, 65535));
      io_en   = ($urandom_range(0, 7) != 0);
      osc3_in = 8'($urandom_range(0, 255));
      env3_in = 8'($urandom_range(0, 255));
      op($urandom_range(0, 1) == 1, a, 8'($urandom_range(0, 255)),
         $urandom_range(0, 30) == 0, "R2 R4 R6 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule